// File: doc/BRIEF.md
# Mixed-Width Register Bus Adapter

The adapter sits between a processor port and a register file whose registers are not all the same width. Every 4-byte slot of the register space has a native width of one, two or four bytes, or is unpopulated. The processor issues byte, halfword or word reads and writes at a byte offset. The adapter looks up the native width of the addressed slot and turns the request into a short sequence of native accesses, one per cycle, over a request/ready handshake.

A request wider than the slot's registers is split into several native accesses at ascending addresses. The most significant part goes first and lands at the lowest address. A read narrower than the register reads the whole aligned register and selects the wanted bytes in big-endian lane order. A write narrower than the register becomes a read-modify-write of the aligned register. Rejected requests produce an error result and issue no native access. Results come back with a one-cycle done pulse.

Top module: `mwbAdapter`

## Requirements
- R1: Only the low 10 bits of `reqAddr` form the offset, so upper address bits have no effect. A masked offset greater than 0x200 ends with `err` set and issues no native access.
- R2: Slot s covers offsets 4s..4s+3, and its width code is `WIDTH_MAP[2s+1:2s]`: 0 unpopulated, 1 byte, 2 halfword, 3 word. The default map gives slot s the code s mod 4. A request to an unpopulated slot ends with `err` set and issues no native access.
- R3: Size codes on `reqSize` and `natSize` are 0 byte, 1 halfword, 2 word. A request whose size equals the native width issues exactly one native access at the request offset.
- R4: A read narrower than the native width issues one native read at the offset aligned to the native width. It returns the addressed bytes, where the lower address is the more significant byte.
- R5: A read wider than the native width issues native reads of native width at offset, offset+N, and so on. The first result becomes the most significant part.
- R6: A write narrower than the native width issues a native read of the aligned register, then a native write of it with only the addressed bytes replaced.
- R7: A write wider than the native width issues native writes at offset, offset+N, and so on. The most significant part of the write data goes first.
- R8: A halfword request at an odd offset, a word request at an offset that is not a multiple of 4, and size code 3 each end with `err` set and issue no native access.
- R9: `natReq` stays high with `natAddr`, `natWrite` and `natWdata` unchanged until `natReady` is seen. A native access completes in each cycle where both are high.
- R10: `reqReady` is high only while the adapter is idle. `done` is a one-cycle pulse: one cycle after acceptance for a rejected request, otherwise one cycle after the last native access completes. Read data is right-aligned and zero-extended on `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Processor request strobe, taken while reqReady is high |
| reqWrite | input | 1 | 1 write, 0 read |
| reqSize | input | 2 | Request size code |
| reqAddr | input | ADDR_W | Byte address; low 10 bits used |
| reqWdata | input | 32 | Write data, right-aligned |
| reqReady | output | 1 | Adapter idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected, valid with done |
| rdData | output | 32 | Read result, valid with done |
| natReq | output | 1 | Native access request |
| natWrite | output | 1 | Native access is a write |
| natSize | output | 2 | Native access size code |
| natAddr | output | 10 | Native access offset |
| natWdata | output | 32 | Native write data, right-aligned |
| natReady | input | 1 | Register file takes the native access |
| natRdata | input | 32 | Native read data, right-aligned, same cycle as natReady |

## Verification
With the register file always ready, a rejected request gives done on the first cycle after acceptance. An accepted one gives done one cycle after its last native access, which is the beat count plus one cycles after acceptance. The bench samples on the falling edge after each rising edge, counts those edges from acceptance and compares the count with these figures. It records every native access as it completes, so the beat count, the first address and the first write data reflect the cycles in which natReq and natReady were both high. A second pass with natReady toggling, and a directed stall with natReady held low, confirm that only completed handshakes advance the sequence and that results still arrive on the done cycle.

// File: rtl/mwbPkg.sv
package mwbPkg;

  localparam int OFF_W    = 10;
  localparam int DATA_W   = 32;
  localparam int SLOT_CNT = 1 << (OFF_W - 2);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } fsmStateT;

  // Strobes and context from control to datapath
  typedef struct packed {
    logic       load;    // request accepted without error
    logic       rdBeat;  // a native read completes this cycle
    logic [1:0] lgS;     // log2 of request bytes
    logic [1:0] lgN;     // log2 of native bytes
    logic [1:0] lane;    // byte position inside the native register
    logic       rmw;     // narrow write: read then merge
    logic       wide;    // request wider than native register
    logic [1:0] beat;    // index of the current native access
  } dpStrobeT;

  function automatic logic [2*SLOT_CNT-1:0] defaultMap();
    logic [2*SLOT_CNT-1:0] m;
    m = '0;
    for (int s = 0; s < SLOT_CNT; s++) begin
      m[2*s +: 2] = 2'(s % 4);
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] laneMask(input logic [1:0] lg);
    if (lg >= 2'd2) return '1;
    return DATA_W'((64'd1 << (8 << lg)) - 64'd1);
  endfunction

endpackage

// File: rtl/mwbCtrl.sv
module mwbCtrl
  import mwbPkg::*;
#(
  parameter int                 ADDR_W = 32,
  parameter logic [OFF_W-1:0]   LIMIT  = 10'h200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        slotCode,
  output logic              reqReady,
  output logic              done,
  output logic              err,
  output logic              natReq,
  output logic              natWrite,
  output logic [1:0]        natSize,
  output logic [OFF_W-1:0]  natAddr,
  input  logic              natReady,
  output dpStrobeT          strobe
);

  fsmStateT           state;
  logic               rWrite;
  logic               rErr;
  logic [1:0]         rLgS;
  logic [1:0]         rLgN;
  logic [1:0]         beatIdx;
  logic [1:0]         lastBeat;
  logic [OFF_W-1:0]   rOff;

  logic [OFF_W-1:0]   reqOff;
  logic               accept;
  logic               misal;
  logic               badReq;
  logic [1:0]         lgNReq;
  logic [1:0]         lastReq;
  logic               wide;
  logic               rmw;
  logic               fire;
  logic [OFF_W-1:0]   nMask;
  logic [OFF_W-1:0]   stepOff;

  assign reqOff = reqAddr[OFF_W-1:0];

  // Request decode at acceptance
  always_comb begin
    accept = reqValid && (state == ST_IDLE);
    lgNReq = slotCode - 2'd1;
    misal  = (reqSize == 2'd1 && reqOff[0]) ||
             (reqSize == 2'd2 && reqOff[1:0] != 2'b00);
    badReq = (reqOff > LIMIT) || (slotCode == 2'd0) ||
             (reqSize == 2'd3) || misal;
    if (reqSize > lgNReq) begin
      lastReq = ((reqSize - lgNReq) == 2'd2) ? 2'd3 : 2'd1;
    end else if (reqWrite && (reqSize < lgNReq)) begin
      lastReq = 2'd1;
    end else begin
      lastReq = 2'd0;
    end
  end

  // Native access generation
  always_comb begin
    wide    = rLgS > rLgN;
    rmw     = rWrite && (rLgS < rLgN);
    nMask   = {{(OFF_W-2){1'b0}},
               (rLgN == 2'd2) ? 2'b11 : ((rLgN == 2'd1) ? 2'b01 : 2'b00)};
    stepOff = {{(OFF_W-2){1'b0}}, beatIdx} << rLgN;
    natAddr = wide ? (rOff + stepOff) : (rOff & ~nMask);
    natWrite = rWrite && !(rmw && beatIdx == 2'd0);
    natSize  = rLgN;
    natReq   = (state == ST_RUN);
    fire     = natReq && natReady;
  end

  assign reqReady = (state == ST_IDLE);
  assign done     = (state == ST_DONE);
  assign err      = (state == ST_DONE) && rErr;

  always_comb begin
    strobe.load   = accept && !badReq;
    strobe.rdBeat = fire && !natWrite;
    strobe.lgS    = strobe.load ? reqSize : rLgS;
    strobe.lgN    = rLgN;
    strobe.lane   = rOff[1:0] & nMask[1:0];
    strobe.rmw    = rmw;
    strobe.wide   = wide;
    strobe.beat   = beatIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rWrite   <= 1'b0;
      rErr     <= 1'b0;
      rLgS     <= 2'd0;
      rLgN     <= 2'd0;
      beatIdx  <= 2'd0;
      lastBeat <= 2'd0;
      rOff     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            rErr    <= badReq;
            beatIdx <= 2'd0;
            if (badReq) begin
              state <= ST_DONE;
            end else begin
              state    <= ST_RUN;
              rWrite   <= reqWrite;
              rLgS     <= reqSize;
              rLgN     <= lgNReq;
              rOff     <= reqOff;
              lastBeat <= lastReq;
            end
          end
        end
        ST_RUN: begin
          if (fire) begin
            if (beatIdx == lastBeat) begin
              state <= ST_DONE;
            end else begin
              beatIdx <= beatIdx + 2'd1;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/mwbData.sv
module mwbData
  import mwbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] natRdata,
  output logic [DATA_W-1:0] natWdata,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] accReg;
  logic [DATA_W-1:0] wReg;
  logic [DATA_W-1:0] holdReg;

  logic [DATA_W-1:0] maskN;
  logic [DATA_W-1:0] maskS;
  logic [DATA_W-1:0] narrowSel;
  logic [DATA_W-1:0] wideAcc;
  int                nBytes;
  int                sBytes;
  int                posR;
  int                posW;

  always_comb begin
    nBytes = 1 << strobe.lgN;
    sBytes = 1 << strobe.lgS;
    maskN  = laneMask(strobe.lgN);
    maskS  = laneMask(strobe.lgS);
    // bit position of the addressed bytes inside a native register
    posR = 8 * (nBytes - sBytes - int'(strobe.lane));
    if (posR < 0) posR = 0;
    // bit position of the chunk sent on the current wide beat
    posW = 8 * (sBytes - nBytes * (int'(strobe.beat) + 1));
    if (posW < 0) posW = 0;
    narrowSel = (natRdata >> posR) & maskS;
    wideAcc   = (accReg << (8 * nBytes)) | (natRdata & maskN);
    if (strobe.rmw) begin
      natWdata = (holdReg & ~(maskS << posR)) | (wReg << posR);
    end else begin
      natWdata = (wReg >> posW) & maskN;
    end
  end

  assign rdData = accReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg  <= '0;
      wReg    <= '0;
      holdReg <= '0;
    end else if (strobe.load) begin
      accReg <= '0;
      wReg   <= reqWdata & laneMask(strobe.lgS);
    end else if (strobe.rdBeat) begin
      if (strobe.wide) begin
        accReg <= wideAcc;
      end else if (strobe.rmw) begin
        holdReg <= natRdata & maskN;
      end else begin
        accReg <= narrowSel;
      end
    end
  end

endmodule

// File: rtl/mwbAdapter.sv
module mwbAdapter
  import mwbPkg::*;
#(
  parameter int                    ADDR_W    = 32,
  parameter logic [OFF_W-1:0]      LIMIT     = 10'h200,
  parameter logic [2*SLOT_CNT-1:0] WIDTH_MAP = defaultMap()
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              reqReady,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdData,
  output logic              natReq,
  output logic              natWrite,
  output logic [1:0]        natSize,
  output logic [9:0]        natAddr,
  output logic [31:0]       natWdata,
  input  logic              natReady,
  input  logic [31:0]       natRdata
);

  localparam int SLOT_W = OFF_W - 2;

  logic [SLOT_W-1:0] slotIdx;
  logic [1:0]        slotCode;
  dpStrobeT          strobe;

  assign slotIdx  = reqAddr[OFF_W-1:2];
  assign slotCode = WIDTH_MAP[2*slotIdx +: 2];

  mwbCtrl #(
    .ADDR_W (ADDR_W),
    .LIMIT  (LIMIT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqAddr  (reqAddr),
    .slotCode (slotCode),
    .reqReady (reqReady),
    .done     (done),
    .err      (err),
    .natReq   (natReq),
    .natWrite (natWrite),
    .natSize  (natSize),
    .natAddr  (natAddr),
    .natReady (natReady),
    .strobe   (strobe)
  );

  mwbData u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqWdata (reqWdata),
    .natRdata (natRdata),
    .natWdata (natWdata),
    .rdData   (rdData)
  );

endmodule

// File: rtl/mwbAdapterChk.sv
module mwbAdapterChk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        done,
  input logic        natReq,
  input logic        natReady,
  input logic [9:0]  natAddr,
  input logic        natWrite,
  input logic [31:0] natWdata
);

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && reqReady);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    natReq && !natReady |=> natReq && $stable(natAddr) &&
                            $stable(natWrite) && $stable(natWdata));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(natReq && reqReady));

  // R10
  start_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(natReq) |-> $past(reqValid && reqReady));

endmodule

bind mwbAdapter mwbAdapterChk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .done     (done),
  .natReq   (natReq),
  .natReady (natReady),
  .natAddr  (natAddr),
  .natWrite (natWrite),
  .natWdata (natWdata)
);

// File: tb/mwbAdapter_tb.sv
module mwbAdapter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, done, err;
  logic [31:0] rdData;
  logic        natReq, natWrite;
  logic [1:0]  natSize;
  logic [9:0]  natAddr;
  logic [31:0] natWdata;
  logic        natReady = 1'b1;
  logic [31:0] natRdata;

  always #5 clk = ~clk;

  mwbAdapter u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .done(done), .err(err), .rdData(rdData),
    .natReq(natReq), .natWrite(natWrite), .natSize(natSize),
    .natAddr(natAddr), .natWdata(natWdata), .natReady(natReady),
    .natRdata(natRdata)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // register file model and expected contents
  logic [7:0] mem    [0:1023];
  logic [7:0] shadow [0:1023];

  always_comb begin
    natRdata = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < (1 << natSize)) natRdata = {natRdata[23:0], mem[natAddr + 10'(i)]};
    end
  end

  always @(posedge clk) begin
    if (natReq && natReady && natWrite) begin
      for (int i = 0; i < 4; i++) begin
        if (i < (1 << natSize))
          mem[natAddr + 10'(i)] <= natWdata[8*((1 << natSize) - 1 - i) +: 8];
      end
    end
  end

  // 0: always ready, 1: toggling, 2: held low
  int readyMode = 0;
  always @(posedge clk) begin
    if (readyMode == 0) natReady <= 1'b1;
    else if (readyMode == 1) natReady <= ~natReady;
    else natReady <= 1'b0;
  end

  // native access monitor
  int          beats = 0;
  logic [9:0]  firstAddr;
  logic [31:0] firstWdata;
  always @(negedge clk) begin
    if (natReq && natReady) begin
      if (beats == 0) begin
        firstAddr  = natAddr;
        firstWdata = natWdata;
      end
      beats = beats + 1;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: act %0d cycles exp fewer", cycles);
      errors = errors + 1;
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: act %h exp %h", tag, what, act, exp);
    end
  endtask

  // expectations derived from the requirements
  function automatic bit expBad(input logic [1:0] sz, input logic [31:0] addr);
    logic [9:0] off;
    off = addr[9:0];
    return (off > 10'h200) || (off[3:2] == 2'd0) || (sz == 2'd3) ||
           (sz == 2'd1 && off[0]) || (sz == 2'd2 && off[1:0] != 2'b00);
  endfunction

  function automatic int expBeats(input logic wr, input logic [1:0] sz,
                                  input logic [31:0] addr);
    int lgN;
    lgN = int'(addr[3:2]) - 1;
    if (int'(sz) > lgN) return 1 << (int'(sz) - lgN);
    if (wr && int'(sz) < lgN) return 2;
    return 1;
  endfunction

  function automatic string tagFor(input logic wr, input logic [1:0] sz,
                                   input logic [31:0] addr);
    int lgN;
    lgN = int'(addr[3:2]) - 1;
    if (expBad(sz, addr)) begin
      if (addr[9:0] > 10'h200) return "R1";
      if (addr[3:2] == 2'd0) return "R2";
      return "R8";
    end
    if (int'(sz) == lgN) return "R3";
    if (int'(sz) < lgN) return wr ? "R6" : "R4";
    return wr ? "R7" : "R5";
  endfunction

  task automatic issue(input logic wr, input logic [1:0] sz,
                       input logic [31:0] addr, input logic [31:0] wd,
                       output int lat);
    @(negedge clk);
    beats    = 0;
    reqValid = 1'b1;
    reqWrite = wr;
    reqSize  = sz;
    reqAddr  = addr;
    reqWdata = wd;
    @(posedge clk);
    #1 reqValid = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat = lat + 1;
    end while (!done && lat < 200);
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
  } vecT;

  localparam int NV = 33;
  localparam vecT VECS [NV] = '{
    '{1'b0, 2'd0, 32'h0000_0005, 32'h0},
    '{1'b0, 2'd1, 32'h0000_0004, 32'h0},
    '{1'b0, 2'd2, 32'h0000_0004, 32'h0},
    '{1'b0, 2'd0, 32'h0000_0009, 32'h0},
    '{1'b0, 2'd1, 32'h0000_000A, 32'h0},
    '{1'b0, 2'd2, 32'h0000_0008, 32'h0},
    '{1'b0, 2'd0, 32'h0000_000E, 32'h0},
    '{1'b0, 2'd0, 32'h0000_000F, 32'h0},
    '{1'b0, 2'd1, 32'h0000_000E, 32'h0},
    '{1'b0, 2'd1, 32'h0000_000C, 32'h0},
    '{1'b0, 2'd2, 32'h0000_000C, 32'h0},
    '{1'b1, 2'd0, 32'h0000_0006, 32'hFFFF_FF11},
    '{1'b1, 2'd1, 32'h0000_0004, 32'h0000_A1B2},
    '{1'b1, 2'd2, 32'h0000_0014, 32'hC3D4_E5F6},
    '{1'b1, 2'd0, 32'h0000_000B, 32'h0000_005A},
    '{1'b1, 2'd1, 32'h0000_0018, 32'h0000_7788},
    '{1'b1, 2'd2, 32'h0000_0028, 32'h99AA_BBCC},
    '{1'b1, 2'd0, 32'h0000_000D, 32'h0000_003C},
    '{1'b1, 2'd1, 32'h0000_000E, 32'hABCD_1234},
    '{1'b1, 2'd2, 32'h0000_001C, 32'hDEAD_BEEF},
    '{1'b1, 2'd0, 32'h0000_001E, 32'h0000_0077},
    '{1'b0, 2'd2, 32'h0000_0004, 32'h0},
    '{1'b0, 2'd2, 32'h0000_0008, 32'h0},
    '{1'b0, 2'd2, 32'h0000_000C, 32'h0},
    '{1'b0, 2'd2, 32'h0000_0014, 32'h0},
    '{1'b0, 2'd2, 32'h0000_0028, 32'h0},
    '{1'b0, 2'd2, 32'h0000_001C, 32'h0},
    '{1'b0, 2'd0, 32'hABCD_0005, 32'h0},
    '{1'b0, 2'd2, 32'h0000_0000, 32'h0},
    '{1'b1, 2'd0, 32'h0000_0010, 32'h55},
    '{1'b0, 2'd0, 32'h0000_0205, 32'h0},
    '{1'b1, 2'd1, 32'h0000_0005, 32'h1234},
    '{1'b0, 2'd3, 32'h0000_000C, 32'h0}
  };

  task automatic runVec(input vecT v, input bit timed);
    int          lat;
    int          sB;
    int          nB;
    bit          bad;
    int          nBeats;
    string       tag;
    logic [9:0]  off;
    logic [9:0]  slotBase;
    logic [31:0] expData;
    logic [31:0] wm;
    logic [9:0]  expFirst;
    bit          memOk;
    off      = v.addr[9:0];
    slotBase = {off[9:2], 2'b00};
    sB       = 1 << v.sz;
    nB       = (v.addr[3:2] == 2'd3) ? 4 : int'(v.addr[3:2]);
    bad      = expBad(v.sz, v.addr);
    tag      = tagFor(v.wr, v.sz, v.addr);
    nBeats   = bad ? 0 : expBeats(v.wr, v.sz, v.addr);
    issue(v.wr, v.sz, v.addr, v.wd, lat);
    check(done == 1'b1, "R10", "done seen", 32'(done), 32'd1);
    check(err == bad, tag, "err flag", 32'(err), 32'(bad));
    check(beats == nBeats, tag, "native access count", 32'(beats), 32'(nBeats));
    if (timed)
      check(lat == nBeats + 1, "R10", "done latency", 32'(lat), 32'(nBeats + 1));
    if (!bad) begin
      expFirst = (sB > nB) ? off : (off & ~10'(nB - 1));
      check(firstAddr == expFirst, tag, "first native address",
            32'(firstAddr), 32'(expFirst));
      if (v.wr) begin
        wm = (sB == 4) ? v.wd : (v.wd & ((32'd1 << (8 * sB)) - 32'd1));
        if (sB > nB) begin
          expData = (wm >> (8 * (sB - nB))) & ((32'd1 << (8 * nB)) - 32'd1);
          check(firstWdata == expData, "R7", "first wide write part",
                firstWdata, expData);
        end
        for (int i = 0; i < sB; i++)
          shadow[off + 10'(i)] = wm[8*(sB - 1 - i) +: 8];
      end else begin
        expData = '0;
        for (int i = 0; i < sB; i++)
          expData = {expData[23:0], shadow[off + 10'(i)]};
        check(rdData == expData, tag, "read data", rdData, expData);
      end
    end
    @(negedge clk);
    memOk = 1'b1;
    for (int i = 0; i < 4; i++)
      if (mem[slotBase + 10'(i)] !== shadow[slotBase + 10'(i)]) memOk = 1'b0;
    check(memOk, tag, "slot contents", {mem[slotBase], mem[slotBase + 10'd1],
          mem[slotBase + 10'd2], mem[slotBase + 10'd3]},
          {shadow[slotBase], shadow[slotBase + 10'd1],
           shadow[slotBase + 10'd2], shadow[slotBase + 10'd3]});
    check(done == 1'b0, "R10", "done single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    int lat;
    for (int i = 0; i < 1024; i++) begin
      mem[i]    = 8'(i * 29 + 7);
      shadow[i] = 8'(i * 29 + 7);
    end
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R10", "reset reqReady", 32'(reqReady), 32'd1);
    check(done == 1'b0, "R10", "reset done", 32'(done), 32'd0);
    check(natReq == 1'b0, "R9", "reset natReq", 32'(natReq), 32'd0);
    rstN = 1'b1;

    for (int p = 0; p < 2; p++) begin
      readyMode = p;
      for (int k = 0; k < NV; k++) runVec(VECS[k], p == 0);
    end

    // directed stall: a word read from byte registers held by natReady low
    readyMode = 2;
    repeat (2) @(negedge clk);
    @(negedge clk);
    beats    = 0;
    reqValid = 1'b1;
    reqWrite = 1'b0;
    reqSize  = 2'd2;
    reqAddr  = 32'h24;
    @(posedge clk);
    #1 reqValid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(natReq == 1'b1, "R9", "request held in stall", 32'(natReq), 32'd1);
      check(natAddr == 10'h024, "R9", "address held in stall",
            32'(natAddr), 32'h24);
    end
    check(beats == 0, "R9", "no completion while not ready", 32'(beats), 32'd0);
    readyMode = 0;
    lat = 0;
    do begin
      @(negedge clk);
      lat = lat + 1;
    end while (!done && lat < 200);
    check(beats == 4, "R5", "stalled wide read count", 32'(beats), 32'd4);
    check(rdData == {shadow[36], shadow[37], shadow[38], shadow[39]}, "R5",
          "stalled wide read data", rdData,
          {shadow[36], shadow[37], shadow[38], shadow[39]});

    repeat (2) @(negedge clk);
    summary();
  end

endmodule